// File: doc/BRIEF.md
# Chaining DMA Descriptor Engine

This block moves 32-bit words between host memory and local endpoint memory by walking a chain of descriptors that software has placed in a table in host memory. Software fills in a four-word header through a 32-bit register write port: global control flags, then the table base address in two halves, and last the index of the final ready descriptor. The write of that last index is what launches the chain. The engine then reads each descriptor from the table in order. It moves the number of words the descriptor asks for. After each descriptor it can write the completed index back into the table's workspace and can raise an interrupt pulse.

One instance serves one direction, chosen by the `TO_LOCAL` parameter. When `TO_LOCAL` is 1, data is read from host memory and written to local memory. When it is 0, the direction is reversed. Both memory ports use the same request/acknowledge handshake. Software detects completion by polling the written-back index until it equals the last-ready index. It can abandon a chain at any time with a soft-reset write.

Top module: `cdma_engine`

## Requirements
- R1: Header word 0 (register address 0) holds the global flags in bits 31:16. Word 1 holds the table base address bits 63:32 and word 2 holds bits 31:0. Writes to words 0, 1 and 2 take effect only while the engine is idle. Writes to them while busy leave the running chain unchanged.
- R2: A write to word 3 while idle, with bits 15:0 (the last-ready index, zero-based) at most 254, starts a chain. `busy` is high in the cycle after that write. A write with an index above 254 starts nothing.
- R3: A write to word 3 while busy is ignored. The chain in progress keeps its original last-ready index.
- R4: Descriptor i is read from host addresses base+0x10+16*i, +4, +8, +12, in that order. Descriptors are read in ascending index order from 0 up to the last-ready index. Descriptor word 0 bits 15:0 give the length in words and bit 16 is the local flag. Word 1 is the local byte address. Word 2 is the host address bits 63:32 and word 3 is bits 31:0.
- R5: A descriptor of length N copies N words, one per 4-byte step of ascending address, from the source address to the destination address. With `TO_LOCAL`=1 the source is the host address and the destination is the local address.
- R6: A descriptor of length zero completes without any data access.
- R7: After a descriptor completes, the engine writes its index into bits 15:0 of the host word at base+0x0C, with bits 31:16 zero. This happens when global flag bit 18 or the descriptor's local flag is set, and it always happens for the final descriptor.
- R8: `irq` pulses high for exactly one cycle per completed descriptor whose local flag or global flag bit 17 is set. It never pulses otherwise.
- R9: `busy` stays high until the cycle after the final writeback is acknowledged, and then drops.
- R10: Writing 0x0000FFFF to word 0 returns the engine to idle in the next cycle. No host or local request follows until a new start.
- R11: After reset `busy`, `irq`, `hostReq` and `locReq` are low.
- R12: A memory request holds its address and direction until it is acknowledged; only a soft reset may withdraw it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Header register write strobe |
| regWrAddr | input | 2 | Header word select |
| regWrData | input | 32 | Header write data |
| hostReq | output | 1 | Host memory request |
| hostWe | output | 1 | Host request is a write |
| hostAddr | output | 64 | Host byte address |
| hostWdata | output | 32 | Host write data |
| hostAck | input | 1 | Host request accepted; read data valid |
| hostRdata | input | 32 | Host read data |
| locReq | output | 1 | Local memory request |
| locWe | output | 1 | Local request is a write |
| locAddr | output | LOC_AW | Local byte address |
| locWdata | output | 32 | Local write data |
| locAck | input | 1 | Local request accepted; read data valid |
| locRdata | input | 32 | Local read data |
| busy | output | 1 | Chain in progress |
| irq | output | 1 | One-cycle completion interrupt pulse |

## Verification
A register write can land in the same cycle as engine activity. A start or header write can collide with a running chain, and a soft reset can collide with an outstanding memory request. The bench issues start and table-address writes a few cycles into a long chain. It then judges from the resulting destination words and the writeback log that the original chain ran to its original last index. It also fires a soft reset while requests are pending and watches that both request lines stay low afterwards. Random memory latencies make descriptor fetches, data moves and writebacks interleave differently on every chain.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  localparam int DESC_BYTES  = 16;
  localparam int DESC_BASE   = 16;
  localparam int WB_OFFSET   = 12;
  localparam logic [31:0] SOFT_RESET_WORD = 32'h0000_FFFF;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_SRC, S_SNK, S_DONE, S_WB
  } cdmaState_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_FETCH, OP_SRC, OP_SNK, OP_WB
  } busOp_t;

  typedef struct packed {
    busOp_t op;
    logic   clrIdx;
    logic   incIdx;
    logic   capDesc;
    logic   capData;
    logic   stepWord;
  } dpCtl_t;
endpackage

// File: rtl/cdma_datapath.sv
module cdma_datapath
  import cdma_pkg::*;
#(
  parameter bit TO_LOCAL    = 1'b1,
  parameter int TABLE_BYTES = 4096,
  parameter int LOC_AW      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              busy,
  input  logic              regWrEn,
  input  logic [1:0]        regWrAddr,
  input  logic [31:0]       regWrData,
  output logic              startHit,
  output logic              softHit,
  output logic              opAck,
  output logic              fetchLast,
  output logic              remainZero,
  output logic              remainOne,
  output logic              isLast,
  output logic              irqWanted,
  output logic              wbWanted,
  output logic              hostReq,
  output logic              hostWe,
  output logic [63:0]       hostAddr,
  output logic [31:0]       hostWdata,
  input  logic              hostAck,
  input  logic [31:0]       hostRdata,
  output logic              locReq,
  output logic              locWe,
  output logic [LOC_AW-1:0] locAddr,
  output logic [31:0]       locWdata,
  input  logic              locAck,
  input  logic [31:0]       locRdata
);
  localparam int MAX_LAST = TABLE_BYTES / DESC_BYTES - 2;
  localparam int IDX_W    = 16;

  logic             gIrq, gWb, dFlag;
  logic [63:0]      tblAddr, hostPtr;
  logic [IDX_W-1:0] lastIdx, idx, remain;
  logic [1:0]       fw;
  logic [LOC_AW-1:0] locPtr;
  logic [31:0]      dataBuf, srcData;
  logic             hdrWrOk;

  assign softHit  = regWrEn && regWrAddr == 2'd0 && regWrData == SOFT_RESET_WORD;
  assign hdrWrOk  = regWrEn && !busy && !softHit;
  assign startHit = hdrWrOk && regWrAddr == 2'd3 && regWrData[15:0] <= IDX_W'(MAX_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gIrq <= 1'b0; gWb <= 1'b0; dFlag <= 1'b0;
      tblAddr <= '0; hostPtr <= '0; lastIdx <= '0; idx <= '0;
      remain <= '0; fw <= '0; locPtr <= '0; dataBuf <= '0;
    end else begin
      if (hdrWrOk) begin
        case (regWrAddr)
          2'd0: begin gIrq <= regWrData[17]; gWb <= regWrData[18]; end
          2'd1: tblAddr[63:32] <= regWrData;
          2'd2: tblAddr[31:0]  <= regWrData;
          default: if (startHit) lastIdx <= regWrData[15:0];
        endcase
      end
      if (ctl.clrIdx) begin idx <= '0; fw <= '0; end
      if (ctl.incIdx) idx <= idx + 1'b1;
      if (ctl.capDesc) begin
        fw <= fw + 1'b1;
        case (fw)
          2'd0: begin remain <= hostRdata[15:0]; dFlag <= hostRdata[16]; end
          2'd1: locPtr <= hostRdata[LOC_AW-1:0];
          2'd2: hostPtr[63:32] <= hostRdata;
          default: hostPtr[31:0] <= hostRdata;
        endcase
      end
      if (ctl.capData) dataBuf <= srcData;
      if (ctl.stepWord) begin
        remain  <= remain - 1'b1;
        locPtr  <= locPtr + LOC_AW'(4);
        hostPtr <= hostPtr + 64'd4;
      end
    end
  end

  assign fetchLast  = fw == 2'd3;
  assign remainZero = remain == '0;
  assign remainOne  = remain == IDX_W'(1);
  assign isLast     = idx == lastIdx;
  assign irqWanted  = gIrq || dFlag;
  assign wbWanted   = gWb || dFlag;

  generate
    if (TO_LOCAL) begin : g_toLocal
      assign hostReq = ctl.op == OP_FETCH || ctl.op == OP_WB || ctl.op == OP_SRC;
      assign hostWe  = ctl.op == OP_WB;
      assign locReq  = ctl.op == OP_SNK;
      assign locWe   = 1'b1;
      assign srcData = hostRdata;
    end else begin : g_toHost
      assign hostReq = ctl.op == OP_FETCH || ctl.op == OP_WB || ctl.op == OP_SNK;
      assign hostWe  = ctl.op == OP_WB || ctl.op == OP_SNK;
      assign locReq  = ctl.op == OP_SRC;
      assign locWe   = 1'b0;
      assign srcData = locRdata;
    end
  endgenerate

  always_comb begin
    case (ctl.op)
      OP_FETCH: hostAddr = tblAddr + 64'(DESC_BASE) + (64'(idx) << 4) + (64'(fw) << 2);
      OP_WB:    hostAddr = tblAddr + 64'(WB_OFFSET);
      default:  hostAddr = hostPtr;
    endcase
  end

  assign hostWdata = (ctl.op == OP_WB) ? {16'b0, idx} : dataBuf;
  assign locAddr   = locPtr;
  assign locWdata  = dataBuf;
  assign opAck     = (hostReq && hostAck) || (locReq && locAck);
endmodule

// File: rtl/cdma_control.sv
module cdma_control
  import cdma_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startHit,
  input  logic   softHit,
  input  logic   opAck,
  input  logic   fetchLast,
  input  logic   remainZero,
  input  logic   remainOne,
  input  logic   isLast,
  input  logic   irqWanted,
  input  logic   wbWanted,
  output dpCtl_t ctl,
  output logic   busy,
  output logic   irq
);
  cdmaState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN)        state <= S_IDLE;
    else if (softHit) state <= S_IDLE;
    else              state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      S_IDLE: if (startHit) begin ctl.clrIdx = 1'b1; nextState = S_FETCH; end
      S_FETCH: begin
        ctl.op = OP_FETCH;
        if (opAck) begin
          ctl.capDesc = 1'b1;
          if (fetchLast) nextState = S_CHECK;
        end
      end
      S_CHECK: nextState = remainZero ? S_DONE : S_SRC;
      S_SRC: begin
        ctl.op = OP_SRC;
        if (opAck) begin ctl.capData = 1'b1; nextState = S_SNK; end
      end
      S_SNK: begin
        ctl.op = OP_SNK;
        if (opAck) begin
          ctl.stepWord = 1'b1;
          nextState = remainOne ? S_DONE : S_SRC;
        end
      end
      S_DONE: begin
        if (wbWanted || isLast) nextState = S_WB;
        else begin ctl.incIdx = 1'b1; nextState = S_FETCH; end
      end
      S_WB: begin
        ctl.op = OP_WB;
        if (opAck) begin
          if (isLast) nextState = S_IDLE;
          else begin ctl.incIdx = 1'b1; nextState = S_FETCH; end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = state != S_IDLE;
  assign irq  = state == S_DONE && irqWanted;
endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
  import cdma_pkg::*;
#(
  parameter bit TO_LOCAL    = 1'b1,
  parameter int TABLE_BYTES = 4096,
  parameter int LOC_AW      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regWrAddr,
  input  logic [31:0]       regWrData,
  output logic              hostReq,
  output logic              hostWe,
  output logic [63:0]       hostAddr,
  output logic [31:0]       hostWdata,
  input  logic              hostAck,
  input  logic [31:0]       hostRdata,
  output logic              locReq,
  output logic              locWe,
  output logic [LOC_AW-1:0] locAddr,
  output logic [31:0]       locWdata,
  input  logic              locAck,
  input  logic [31:0]       locRdata,
  output logic              busy,
  output logic              irq
);
  dpCtl_t ctl;
  logic startHit, softHit, opAck, fetchLast, remainZero, remainOne;
  logic isLast, irqWanted, wbWanted;

  cdma_control i_control (
    .clk(clk), .rstN(rstN), .startHit(startHit), .softHit(softHit),
    .opAck(opAck), .fetchLast(fetchLast), .remainZero(remainZero),
    .remainOne(remainOne), .isLast(isLast), .irqWanted(irqWanted),
    .wbWanted(wbWanted), .ctl(ctl), .busy(busy), .irq(irq)
  );

  cdma_datapath #(
    .TO_LOCAL(TO_LOCAL), .TABLE_BYTES(TABLE_BYTES), .LOC_AW(LOC_AW)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busy(busy),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .startHit(startHit), .softHit(softHit), .opAck(opAck),
    .fetchLast(fetchLast), .remainZero(remainZero), .remainOne(remainOne),
    .isLast(isLast), .irqWanted(irqWanted), .wbWanted(wbWanted),
    .hostReq(hostReq), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostAck(hostAck), .hostRdata(hostRdata),
    .locReq(locReq), .locWe(locWe), .locAddr(locAddr), .locWdata(locWdata),
    .locAck(locAck), .locRdata(locRdata)
  );
endmodule

// File: rtl/cdma_engine_chk.sv
module cdma_engine_chk #(
  parameter int TABLE_BYTES = 4096,
  parameter int LOC_AW      = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [1:0]        regWrAddr,
  input logic [31:0]       regWrData,
  input logic              hostReq,
  input logic              hostWe,
  input logic [63:0]       hostAddr,
  input logic [31:0]       hostWdata,
  input logic              hostAck,
  input logic [31:0]       hostRdata,
  input logic              locReq,
  input logic              locWe,
  input logic [LOC_AW-1:0] locAddr,
  input logic [31:0]       locWdata,
  input logic              locAck,
  input logic [31:0]       locRdata,
  input logic              busy,
  input logic              irq
);
  localparam int MAX_LAST = TABLE_BYTES / 16 - 2;
  logic softWr, bigStart;
  assign softWr   = regWrEn && regWrAddr == 2'd0 && regWrData == 32'h0000_FFFF;
  assign bigStart = regWrEn && regWrAddr == 2'd3 && regWrData[15:0] > 16'(MAX_LAST);

  // R12
  host_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostReq && !hostAck && !softWr |=> hostReq && $stable(hostAddr) && $stable(hostWe));
  // R12
  loc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    locReq && !locAck && !softWr |=> locReq && $stable(locAddr) && $stable(locWe));
  // R8
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) irq |=> !irq);
  // R8
  irq_busy_chk: assert property (@(posedge clk) disable iff (!rstN) irq |-> busy);
  // R2
  bad_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy && bigStart |=> !busy);
  // R10
  soft_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    softWr |=> !busy && !hostReq && !locReq);
  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(softWr || (hostReq && hostWe && hostAck)));
endmodule

bind cdma_engine cdma_engine_chk #(.TABLE_BYTES(TABLE_BYTES), .LOC_AW(LOC_AW)) i_chk (.*);

// File: tb/test_cdma_engine.sv
module test_cdma_engine;
  localparam logic [31:0] HI = 32'h0000_0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic hostReq, hostWe, hostAck, locReq, locWe, locAck, busy, irq;
  logic [63:0] hostAddr;
  logic [31:0] hostWdata, hostRdata, locAddr, locWdata, locRdata;

  int nChecks = 0, nFails = 0, irqCount = 0, badAccess = 0;
  int wbLog[$];
  int fetchLog[$];
  logic [31:0] hostMem [0:4095];
  logic [31:0] localMem [0:1023];
  int dLen [0:255];
  int dFlag [0:255];
  int dLoc [0:255];
  int dHost [0:255];

  always #2.5 clk = ~clk;

  cdma_engine i_cdma_engine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .hostReq(hostReq), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostAck(hostAck),
    .hostRdata(hostRdata), .locReq(locReq), .locWe(locWe), .locAddr(locAddr),
    .locWdata(locWdata), .locAck(locAck), .locRdata(locRdata),
    .busy(busy), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // host memory responder
  initial begin
    int hostWait = 0;
    hostAck = 1'b0; hostRdata = '0;
    forever begin
      @(negedge clk);
      if (hostAck) hostAck = 1'b0;
      else if (!hostReq) hostWait = 0;
      else if (hostWait > 0) hostWait--;
      else begin
        if (hostAddr[63:32] != HI || hostAddr[1:0] != 2'b0 || hostAddr[31:14] != 0) badAccess++;
        if (hostWe) begin
          hostMem[hostAddr[13:2]] = hostWdata;
          if (hostAddr[31:0] == 32'hC) wbLog.push_back(int'(hostWdata));
        end else begin
          hostRdata = hostMem[hostAddr[13:2]];
          if (hostAddr[31:0] >= 32'h10 && hostAddr[31:0] < 32'h1000)
            fetchLog.push_back(int'(hostAddr[31:0]));
        end
        hostAck = 1'b1;
        hostWait = $urandom_range(0, 2);
      end
    end
  end

  // local memory responder
  initial begin
    int locWait = 0;
    locAck = 1'b0; locRdata = '0;
    forever begin
      @(negedge clk);
      if (locAck) locAck = 1'b0;
      else if (!locReq) locWait = 0;
      else if (locWait > 0) locWait--;
      else begin
        if (locAddr[31:12] != 0 || locAddr[1:0] != 2'b0) badAccess++;
        if (locWe) localMem[locAddr[11:2]] = locWdata;
        else locRdata = localMem[locAddr[11:2]];
        locAck = 1'b1;
        locWait = $urandom_range(0, 2);
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (irq) irqCount++;
  end

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  function automatic logic [31:0] sentinel(input int w);
    return 32'hA5A5_0000 | 32'(w);
  endfunction

  task automatic placeTable(input int last);
    for (int i = 0; i <= last; i++) begin
      hostMem[4 + 4*i]     = {15'b0, dFlag[i][0], 16'(dLen[i])};
      hostMem[4 + 4*i + 1] = 32'(dLoc[i]);
      hostMem[4 + 4*i + 2] = HI;
      hostMem[4 + 4*i + 3] = 32'(dHost[i]);
    end
    for (int w = 0; w < 1024; w++) localMem[w] = sentinel(w);
  endtask

  task automatic startChain(input int last, input logic [15:0] gctl);
    wbLog.delete(); fetchLog.delete(); irqCount = 0; badAccess = 0;
    regWrite(2'd0, {gctl, 16'(last + 1)});
    regWrite(2'd1, HI);
    regWrite(2'd2, 32'h0);
    regWrite(2'd3, 32'(last));
    check(busy === 1'b1, "R2", "busy after start", longint'(busy), 1);
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    check(!busy, "R9", {tag, " busy dropped"}, longint'(busy), 0);
  endtask

  task automatic verifyChain(input string tag, input int last, input logic [15:0] gctl);
    int mism = 0, zeroBad = 0, expIrq = 0, fetchBad = 0, wbBad = 0;
    int expWb[$];
    for (int i = 0; i <= last; i++) begin
      for (int w = 0; w < dLen[i]; w++)
        if (localMem[dLoc[i]/4 + w] !== hostMem[dHost[i]/4 + w]) mism++;
      if (localMem[dLoc[i]/4 + dLen[i]] !== sentinel(dLoc[i]/4 + dLen[i])) begin
        if (dLen[i] == 0) zeroBad++; else mism++;
      end
      if (gctl[2] || dFlag[i] != 0 || i == last) expWb.push_back(i);
      if (gctl[1] || dFlag[i] != 0) expIrq++;
    end
    check(mism == 0, "R5", {tag, " data mismatches"}, mism, 0);
    check(zeroBad == 0, "R6", {tag, " zero-length touched"}, zeroBad, 0);
    check(irqCount == expIrq, "R8", {tag, " irq pulses"}, irqCount, expIrq);
    check(badAccess == 0, "R4", {tag, " bad addresses"}, badAccess, 0);
    if (fetchLog.size() != 4*(last+1)) fetchBad = 1;
    else for (int k = 0; k < 4*(last+1); k++) if (fetchLog[k] != 16 + 4*k) fetchBad++;
    check(fetchBad == 0, "R4", {tag, " fetch order"}, fetchLog.size(), 4*(last+1));
    if (wbLog.size() != expWb.size()) wbBad = 1;
    else for (int k = 0; k < expWb.size(); k++) if (wbLog[k] != expWb[k]) wbBad++;
    check(wbBad == 0, "R7", {tag, " writeback log"}, wbLog.size(), expWb.size());
  endtask

  task automatic setDesc(input int i, input int len, input int flag);
    dLen[i] = len; dFlag[i] = flag; dLoc[i] = i * 64; dHost[i] = 32'h1000 + i * 64;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(7));
    for (int w = 0; w < 4096; w++) hostMem[w] = $urandom;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(busy === 1'b0, "R11", "busy", longint'(busy), 0);
    check(irq === 1'b0, "R11", "irq", longint'(irq), 0);
    check(hostReq === 1'b0 && locReq === 1'b0, "R11", "requests", longint'(hostReq | locReq), 0);

    // directed: global writeback
    setDesc(0, 4, 0); setDesc(1, 1, 0); setDesc(2, 2, 0);
    placeTable(2); startChain(2, 16'h0004); waitIdle("gwb"); verifyChain("gwb", 2, 16'h0004);

    // directed: zero length in the middle with local flag (R6, R7)
    setDesc(0, 3, 0); setDesc(1, 0, 1); setDesc(2, 5, 0);
    placeTable(2); startChain(2, 16'h0000); waitIdle("local"); verifyChain("local", 2, 16'h0000);

    // directed: single descriptor, global irq only (R8)
    setDesc(0, 8, 0);
    placeTable(0); startChain(0, 16'h0002); waitIdle("girq"); verifyChain("girq", 0, 16'h0002);

    // R3 and R1: header writes while busy are ignored
    for (int i = 0; i < 4; i++) setDesc(i, 6, 0);
    placeTable(3); startChain(3, 16'h0004);
    repeat (5) @(negedge clk);
    regWrite(2'd3, 32'h0);
    regWrite(2'd2, 32'h0000_0100);
    regWrite(2'd0, 32'h0002_0001);
    waitIdle("busywr"); verifyChain("busywr_R3_R1", 3, 16'h0004);

    // R2: index above the limit starts nothing
    regWrite(2'd3, 32'd255);
    repeat (3) @(negedge clk);
    check(busy === 1'b0, "R2", "oversized index start", longint'(busy), 0);

    // R10: soft reset mid-chain
    for (int i = 0; i < 3; i++) setDesc(i, 8, 0);
    placeTable(2); startChain(2, 16'h0004);
    repeat (6) @(negedge clk);
    regWrite(2'd0, 32'h0000_FFFF);
    check(busy === 1'b0, "R10", "busy after soft reset", longint'(busy), 0);
    begin
      int reqSeen = 0;
      repeat (20) begin @(negedge clk); if (hostReq || locReq) reqSeen++; end
      check(reqSeen == 0, "R10", "requests after soft reset", reqSeen, 0);
    end

    // random chains
    for (int c = 0; c < 8; c++) begin
      int last;
      logic [15:0] gctl;
      last = $urandom_range(0, 7);
      gctl = 16'($urandom_range(0, 3) << 1);
      for (int i = 0; i <= last; i++) setDesc(i, $urandom_range(0, 8), $urandom_range(0, 1));
      placeTable(last); startChain(last, gctl); waitIdle("rand"); verifyChain("rand", last, gctl);
    end

    // R2 boundary: largest index, all zero-length
    for (int i = 0; i <= 254; i++) begin
      dLen[i] = 0; dFlag[i] = 0; dLoc[i] = 0; dHost[i] = 32'h1000;
    end
    placeTable(254); startChain(254, 16'h0000); waitIdle("max"); verifyChain("max", 254, 16'h0000);

    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule